// File: doc/BRIEF.md
# ATAPI Device PIO Transfer Engine

This block is the device side of the task file in an ATAPI-style optical drive. The host writes the command, control, feature and 16-bit data registers and reads status, error, interrupt reason, byte count and data. A packet command opens a twelve-byte receive phase. The words the host writes go into a local sector buffer at rising byte offsets. When the packet is complete the engine raises a busy indication and signals the command decoder.

The decoder answers in one of two ways. It can start a data phase, giving a direction, a byte length and a sector count. It can also close the command with a 4-bit result code. Data phases run by PIO through the data register, or by DMA, in which case an outside engine moves the bytes and reports completion. Multi-sector reads re-arm by themselves at the end of each sector and request the next sector from the fetch side. One interrupt line, with pending/mask semantics, tells the host when each phase changes.

Top module: `atapi_pio_engine`

Register selects (`host_sel`): 0 data, 1 error (read) / feature (write), 2 interrupt reason, 3 LBA-low, 4 byte count low, 5 byte count high, 6 status (read) / command (write), 7 alternate status (read) / control (write). Interrupt reason bit 0 marks command/data and bit 1 marks input to the host. Status bit 7 is BSY and bit 3 is DRQ.

## Requirements
- R1: After reset, status reads 0x00, error 0x00, interrupt reason 0x00, LBA-low 0x81 and both byte-count registers 0x00. The interrupt is not pending, the mask is clear, `unit_attn` is 1 and the state is idle.
- R2: Writing command 0xA0 sets status to 0x58 and interrupt reason to 1. The error register becomes {6'b0, feature[1:0]}. A twelve-byte receive phase starts.
- R3: In the receive phase, each data-register write stores its word little-endian at the current even byte offset and moves the offset on by 2. The sixth word ends the phase: status becomes 0xD0 (BSY set, DRQ clear) and `pkt_rdy` pulses for one cycle.
- R4: A decoder transfer start in the busy state with feature bit 0 clear enters a PIO phase. Status becomes 0x58, the error register is cleared and interrupt reason becomes 2 for a read or 0 for a write. The byte count goes into the count registers (low byte at select 4, high byte at select 5) and the interrupt is raised.
- R5: Each data-register read in a PIO read phase returns the buffer word at the current offset and moves the offset on by 2. At the end, if sectors remain, the count is decremented, `sect_req` pulses, and the read restarts at offset 0 with status 0x58, interrupt reason 2 and the interrupt raised. With no sectors left the state goes idle, with status 0x50, interrupt reason 3 and the interrupt raised.
- R6: With feature bit 0 set, a transfer start gives status 0xD0 and leaves the byte-count registers and the interrupt alone. Each `dma_done` in a DMA read with sectors remaining re-arms, pulses `sect_req` and raises the interrupt. Otherwise `dma_done` ends the phase with status 0x50, interrupt reason 3 and the interrupt raised.
- R7: `irq` is the pending flag gated by control bit 1. Setting that bit drops `irq` on the next cycle. Clearing it brings back a pending interrupt on the next cycle.
- R8: A status read (select 6) clears the pending interrupt only when BSY is clear. A read at select 7 never clears it.
- R9: Any command write first clears the pending interrupt. 0x00 forces idle with status 0x51 and raises the interrupt. 0xEF sets status 0x50 and raises it. Any other value except 0xA0 has no further effect.
- R10: A decoder completion in the busy state sets status to 0x51 for a nonzero code or 0x50 for zero, and sets error to {code, 4'h0}. It also sets interrupt reason to 3, goes idle and raises the interrupt. Any accepted decoder response clears `unit_attn`.
- R11: A data-register access outside its matching state is ignored. A read returns 0 and a write stores nothing, and neither moves the offset.
- R12: The last word of a PIO write phase ends it. The state goes idle with status 0x50 and interrupt reason 3, the interrupt is raised and `wdata_rdy` pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (side effects only) |
| host_sel | input | 3 | Register select |
| host_wdata | input | 16 | Host write data (commands use bits 7:0) |
| host_rdata | output | 16 | Read value for the selected register |
| irq | output | 1 | Interrupt request to the host |
| buf_addr | output | LEN_W | Buffer byte address (even) |
| buf_wdata | output | 16 | Buffer write word, low byte at `buf_addr` |
| buf_we | output | 1 | Buffer write enable |
| buf_rdata | input | 16 | Buffer read word at `buf_addr` |
| pkt_rdy | output | 1 | One-cycle pulse: packet is complete in the buffer |
| wdata_rdy | output | 1 | One-cycle pulse: PIO write data is complete |
| sect_req | output | 1 | One-cycle pulse: fetch the next sector |
| unit_attn | output | 1 | Set by reset, cleared by the first decoder response |
| dev_xfer_go | input | 1 | Decoder starts a data phase |
| dev_xfer_rd | input | 1 | 1 = read towards the host, 0 = write |
| dev_xfer_len | input | LEN_W | Phase length in bytes |
| dev_xfer_secs | input | SEC_W | Further sectors after this one (reads) |
| dev_cmd_end | input | 1 | Decoder completes the command without data |
| dev_cmd_err | input | 4 | Completion code |
| dma_done | input | 1 | External DMA finished the current phase |

## Verification
The command flow is driven through four transfer shapes: a data-in PIO read of two sectors, a data-out PIO write, a two-sector DMA read, and a packet that ends with no data phase. Together they separate the status and interrupt-reason values of each state and show whether the multi-sector re-arm fires only on reads. Interrupt handling is probed with status reads while BSY is set and while it is clear, with alternate-status reads, and with the mask toggled while an interrupt is pending. These tell clearing apart from masking. Data accesses in the wrong state are followed by buffer and offset checks, which show whether such accesses are truly ignored.

// File: rtl/atapi_pio_pkg.sv
package atapi_pio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMDRX = 3'd1,
        ST_PIORD = 3'd2,
        ST_PIOWR = 3'd3,
        ST_DMARD = 3'd4,
        ST_DMAWR = 3'd5,
        ST_BUSY  = 3'd6
    } xfer_st_e;

    localparam logic [2:0] SEL_DATA    = 3'd0;
    localparam logic [2:0] SEL_ERRFEAT = 3'd1;
    localparam logic [2:0] SEL_IRSN    = 3'd2;
    localparam logic [2:0] SEL_LBALO   = 3'd3;
    localparam logic [2:0] SEL_CNTLO   = 3'd4;
    localparam logic [2:0] SEL_CNTHI   = 3'd5;
    localparam logic [2:0] SEL_STATCMD = 3'd6;
    localparam logic [2:0] SEL_ALTCTL  = 3'd7;

    localparam logic [7:0] CMD_NOP    = 8'h00;
    localparam logic [7:0] CMD_PACKET = 8'hA0;
    localparam logic [7:0] CMD_SETF   = 8'hEF;

    localparam logic [7:0] STS_RESET  = 8'h00;
    localparam logic [7:0] STS_XFER   = 8'h58;
    localparam logic [7:0] STS_BUSY   = 8'hD0;
    localparam logic [7:0] STS_DONE   = 8'h50;
    localparam logic [7:0] STS_ERR    = 8'h51;
    localparam logic [7:0] STS_BSY    = 8'h80;
    localparam logic [7:0] STS_DRQ    = 8'h08;

    localparam logic [7:0] LBA_LO_RST = 8'h81;

    localparam logic [7:0] IRSN_CMD   = 8'd1;
    localparam logic [7:0] IRSN_IN    = 8'd2;
    localparam logic [7:0] IRSN_OUT   = 8'd0;
    localparam logic [7:0] IRSN_END   = 8'd3;

    localparam int PKT_BYTES = 12;

endpackage

// File: rtl/atapi_irq_gate.sv
module atapi_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raise,
    input  logic mask_wr,
    input  logic mask_val,
    output logic irq,
    output logic pending
);

    logic pend_d, pend_q;
    logic nien_d, nien_q;

    always_comb begin
        pend_d = pend_q;
        nien_d = nien_q;
        if (clr)     pend_d = 1'b0;
        if (raise)   pend_d = 1'b1;
        if (mask_wr) nien_d = mask_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            nien_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
            nien_q <= nien_d;
        end
    end

    assign irq     = pend_q & ~nien_q;
    assign pending = pend_q;

    a_r7_mask_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr && mask_val |=> !irq);
    a_r7_unmask_shows_pending: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr && !mask_val && pend_q && !clr |=> irq);
    a_r9_raise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> pending);

endmodule

// File: rtl/atapi_data_window.sv
module atapi_data_window #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] offset,
    output logic             last
);

    logic [LEN_W-1:0] off_d, off_q;

    always_comb begin
        off_d = off_q;
        if (start)     off_d = '0;
        else if (step) off_d = off_q + LEN_W'(2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= off_d;
    end

    assign offset = off_q;
    // the access in flight is the final one of the phase
    assign last   = ({1'b0, off_q} + (LEN_W+1)'(2)) >= {1'b0, len};

    a_r3_offset_steps_by_two: assert property (@(posedge clk) disable iff (!rst_n)
        step && !start |=> offset == $past(offset) + LEN_W'(2));
    a_r5_start_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> offset == '0);

endmodule

// File: rtl/atapi_pio_engine.sv
module atapi_pio_engine
    import atapi_pio_pkg::*;
#(
    parameter int BUF_BYTES = 2352,
    parameter int SEC_W     = 16,
    parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [2:0]       host_sel,
    input  logic [15:0]      host_wdata,
    output logic [15:0]      host_rdata,
    output logic             irq,
    output logic [LEN_W-1:0] buf_addr,
    output logic [15:0]      buf_wdata,
    output logic             buf_we,
    input  logic [15:0]      buf_rdata,
    output logic             pkt_rdy,
    output logic             wdata_rdy,
    output logic             sect_req,
    output logic             unit_attn,
    input  logic             dev_xfer_go,
    input  logic             dev_xfer_rd,
    input  logic [LEN_W-1:0] dev_xfer_len,
    input  logic [SEC_W-1:0] dev_xfer_secs,
    input  logic             dev_cmd_end,
    input  logic [3:0]       dev_cmd_err,
    input  logic             dma_done
);

    typedef struct packed {
        xfer_st_e         st;
        logic [7:0]       status;
        logic [7:0]       error;
        logic [7:0]       irsn;
        logic [7:0]       cnt_lo;
        logic [7:0]       cnt_hi;
        logic [7:0]       feat;
        logic [LEN_W-1:0] len;
        logic [SEC_W-1:0] secs;
        logic             ua;
        logic             pkt_rdy;
        logic             wdone;
        logic             sreq;
    } eng_t;

    eng_t d, q;

    logic             win_start, win_step, win_last;
    logic [LEN_W-1:0] win_off;
    logic             irq_raise, irq_clr, irq_pend;

    logic cmd_wr, stat_rd, data_wr, data_rd, dec_ok, dma_st;
    assign cmd_wr  = host_wr && host_sel == SEL_STATCMD;
    assign stat_rd = host_rd && host_sel == SEL_STATCMD;
    assign data_wr = host_wr && host_sel == SEL_DATA;
    assign data_rd = host_rd && host_sel == SEL_DATA;
    assign dec_ok  = q.st == ST_BUSY;
    assign dma_st  = q.st == ST_DMARD || q.st == ST_DMAWR;

    assign win_step = (data_wr && (q.st == ST_CMDRX || q.st == ST_PIOWR))
                   || (data_rd && q.st == ST_PIORD);
    assign irq_clr  = cmd_wr || (stat_rd && !q.status[7]);

    always_comb begin
        d           = q;
        d.pkt_rdy   = 1'b0;
        d.wdone     = 1'b0;
        d.sreq      = 1'b0;
        irq_raise   = 1'b0;
        win_start   = 1'b0;
        if (host_wr && host_sel == SEL_ERRFEAT) d.feat = host_wdata[7:0];
        if (cmd_wr) begin
            unique case (host_wdata[7:0])
                CMD_PACKET: begin
                    d.st      = ST_CMDRX;
                    d.status  = STS_XFER;
                    d.error   = {6'b0, q.feat[1:0]};
                    d.irsn    = IRSN_CMD;
                    d.len     = LEN_W'(PKT_BYTES);
                    win_start = 1'b1;
                end
                CMD_NOP: begin
                    d.st      = ST_IDLE;
                    d.status  = STS_ERR;
                    irq_raise = 1'b1;
                end
                CMD_SETF: begin
                    d.status  = STS_DONE;
                    irq_raise = 1'b1;
                end
                default: ;
            endcase
        end else if (win_step && win_last) begin
            irq_raise = 1'b1;
            if (q.st == ST_CMDRX) begin
                d.st      = ST_BUSY;
                d.status  = (q.status & ~STS_DRQ) | STS_BSY;
                d.pkt_rdy = 1'b1;
                irq_raise = 1'b0;
            end else if (q.st == ST_PIORD && q.secs != '0) begin
                d.secs    = q.secs - SEC_W'(1);
                d.sreq    = 1'b1;
                d.status  = STS_XFER;
                d.irsn    = IRSN_IN;
                d.cnt_lo  = q.len[7:0];
                d.cnt_hi  = 8'(q.len >> 8);
                win_start = 1'b1;
            end else begin
                d.st      = ST_IDLE;
                d.status  = q.status & ~STS_DRQ;
                d.irsn    = IRSN_END;
                d.wdone   = q.st == ST_PIOWR;
            end
        end else if (dma_done && dma_st) begin
            irq_raise = 1'b1;
            if (q.st == ST_DMARD && q.secs != '0) begin
                d.secs    = q.secs - SEC_W'(1);
                d.sreq    = 1'b1;
                win_start = 1'b1;
            end else begin
                d.st      = ST_IDLE;
                d.status  = STS_DONE;
                d.irsn    = IRSN_END;
            end
        end else if (dec_ok && dev_xfer_go) begin
            d.ua      = 1'b0;
            d.error   = 8'h00;
            d.len     = dev_xfer_len;
            d.secs    = dev_xfer_rd ? dev_xfer_secs : '0;
            d.irsn    = dev_xfer_rd ? IRSN_IN : IRSN_OUT;
            win_start = 1'b1;
            if (q.feat[0]) begin
                d.st     = dev_xfer_rd ? ST_DMARD : ST_DMAWR;
                d.status = STS_BUSY;
            end else begin
                d.st      = dev_xfer_rd ? ST_PIORD : ST_PIOWR;
                d.status  = STS_XFER;
                d.cnt_lo  = dev_xfer_len[7:0];
                d.cnt_hi  = 8'(dev_xfer_len >> 8);
                irq_raise = 1'b1;
            end
        end else if (dec_ok && dev_cmd_end) begin
            d.ua      = 1'b0;
            d.st      = ST_IDLE;
            d.error   = {dev_cmd_err, 4'h0};
            d.status  = (dev_cmd_err != 4'h0) ? STS_ERR : STS_DONE;
            d.irsn    = IRSN_END;
            irq_raise = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.status <= STS_RESET;
            q.ua     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    atapi_data_window #(.LEN_W(LEN_W)) win_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (win_start),
        .step   (win_step),
        .len    (q.len),
        .offset (win_off),
        .last   (win_last)
    );

    atapi_irq_gate irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (irq_clr),
        .raise    (irq_raise),
        .mask_wr  (host_wr && host_sel == SEL_ALTCTL),
        .mask_val (host_wdata[1]),
        .irq      (irq),
        .pending  (irq_pend)
    );

    always_comb begin
        unique case (host_sel)
            SEL_DATA:    host_rdata = (q.st == ST_PIORD) ? buf_rdata : 16'h0000;
            SEL_ERRFEAT: host_rdata = {8'h00, q.error};
            SEL_IRSN:    host_rdata = {8'h00, q.irsn};
            SEL_LBALO:   host_rdata = {8'h00, LBA_LO_RST};
            SEL_CNTLO:   host_rdata = {8'h00, q.cnt_lo};
            SEL_CNTHI:   host_rdata = {8'h00, q.cnt_hi};
            default:     host_rdata = {8'h00, q.status};
        endcase
    end

    assign buf_addr  = win_off;
    assign buf_wdata = host_wdata;
    assign buf_we    = data_wr && (q.st == ST_CMDRX || q.st == ST_PIOWR);
    assign pkt_rdy   = q.pkt_rdy;
    assign wdata_rdy = q.wdone;
    assign sect_req  = q.sreq;
    assign unit_attn = q.ua;

    a_r2_packet_opens_rx: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && host_wdata[7:0] == CMD_PACKET |=> q.st == ST_CMDRX && q.status == STS_XFER);
    a_r3_pkt_rdy_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_rdy |-> q.st == ST_BUSY && q.status == STS_BUSY);
    a_r3_bsy_drq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.status[7] && q.status[3]));
    a_r8_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !host_wr && !q.status[7] |=> !irq_pend);
    a_r6_dma_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dec_ok && dev_xfer_go && q.feat[0] && !host_wr && !host_rd |=> !irq_pend);

endmodule

// File: tb/atapi_pio_engine_tb_top.sv
`timescale 1ns/1ps
module atapi_pio_engine_tb_top;

    localparam int LW = 12;
    localparam int SW = 16;
    localparam int NB = 2352;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [7:0]  mem [0:NB-1];
    logic        b_wr = 0, b_rd = 0, b_go = 0, b_gord = 0, b_end = 0, b_dma = 0;
    logic [2:0]  b_sel = 0;
    logic [15:0] b_wd = 0;
    logic [LW-1:0] b_glen = 0;
    logic [SW-1:0] b_gsec = 0;
    logic [3:0]  b_code = 0;

    logic [15:0] host_rdata, buf_wdata, buf_rdata;
    logic [LW-1:0] buf_addr;
    logic irq, buf_we, pkt_rdy, wdata_rdy, sect_req, unit_attn;

    atapi_pio_engine dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(b_wr), .host_rd(b_rd), .host_sel(b_sel),
        .host_wdata(b_wd), .host_rdata(host_rdata), .irq(irq), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_we(buf_we), .buf_rdata(buf_rdata), .pkt_rdy(pkt_rdy),
        .wdata_rdy(wdata_rdy), .sect_req(sect_req), .unit_attn(unit_attn),
        .dev_xfer_go(b_go), .dev_xfer_rd(b_gord), .dev_xfer_len(b_glen),
        .dev_xfer_secs(b_gsec), .dev_cmd_end(b_end), .dev_cmd_err(b_code), .dma_done(b_dma)
    );

    assign buf_rdata = (int'(buf_addr) < NB - 1) ? {mem[buf_addr + 1], mem[buf_addr]} : 16'h0;
    always @(posedge clk) if (buf_we) begin
        mem[buf_addr]     <= buf_wdata[7:0];
        mem[buf_addr + 1] <= buf_wdata[15:8];
    end

    // reference model: 0 idle 1 packet rx 2 pio rd 3 pio wr 4 dma rd 5 dma wr 6 busy
    int m_st = 0, m_off = 0, m_len = 0, m_secs = 0;
    logic [7:0] m_status = 8'h00, m_err = 0, m_irsn = 0, m_lo = 0, m_hi = 0, m_feat = 0;
    bit m_pend = 0, m_nien = 0, m_ua = 1, m_pkt = 0, m_wdn = 0, m_sr = 0;
    int n_cmp = 0, n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit rs = 0, cl = 0;
        m_pkt = 0; m_wdn = 0; m_sr = 0;
        if (b_wr && b_sel == 7) m_nien = b_wd[1];
        if (b_wr && b_sel == 1) m_feat = b_wd[7:0];
        if (b_rd && b_sel == 6 && !m_status[7]) cl = 1;
        if (b_wr && b_sel == 6) begin
            cl = 1;
            if (b_wd[7:0] == 8'hA0) begin
                m_st = 1; m_status = 8'h58; m_err = {6'b0, m_feat[1:0]};
                m_irsn = 1; m_len = 12; m_off = 0;
            end else if (b_wd[7:0] == 8'h00) begin
                m_st = 0; m_status = 8'h51; rs = 1;
            end else if (b_wd[7:0] == 8'hEF) begin
                m_status = 8'h50; rs = 1;
            end
        end else if ((b_wr && b_sel == 0 && (m_st == 1 || m_st == 3)) ||
                     (b_rd && b_sel == 0 && m_st == 2)) begin
            m_off += 2;
            if (m_off >= m_len) begin
                if (m_st == 1) begin
                    m_st = 6; m_status = 8'hD0; m_pkt = 1;
                end else if (m_st == 2 && m_secs > 0) begin
                    m_secs--; m_sr = 1; m_off = 0; m_status = 8'h58; m_irsn = 2;
                    m_lo = m_len[7:0]; m_hi = 8'(m_len >> 8); rs = 1;
                end else begin
                    if (m_st == 3) m_wdn = 1;
                    m_st = 0; m_status = 8'h50; m_irsn = 3; rs = 1;
                end
            end
        end else if (b_dma && (m_st == 4 || m_st == 5)) begin
            rs = 1;
            if (m_st == 4 && m_secs > 0) begin
                m_secs--; m_sr = 1; m_off = 0;
            end else begin
                m_st = 0; m_status = 8'h50; m_irsn = 3;
            end
        end else if (m_st == 6 && b_go) begin
            m_ua = 0; m_err = 0; m_len = b_glen; m_off = 0;
            m_secs = b_gord ? int'(b_gsec) : 0;
            m_irsn = b_gord ? 8'd2 : 8'd0;
            if (m_feat[0]) begin
                m_st = b_gord ? 4 : 5; m_status = 8'hD0;
            end else begin
                m_st = b_gord ? 2 : 3; m_status = 8'h58;
                m_lo = b_glen[7:0]; m_hi = 8'(b_glen >> 8); rs = 1;
            end
        end else if (m_st == 6 && b_end) begin
            m_ua = 0; m_st = 0; m_err = {b_code, 4'h0};
            m_status = (b_code != 0) ? 8'h51 : 8'h50; m_irsn = 3; rs = 1;
        end
        if (cl) m_pend = 0;
        if (rs) m_pend = 1;
    endtask

    task automatic cmp_all();
        chk("R7 irq", int'(irq), int'(m_pend && !m_nien));
        chk("R3 pkt_rdy", int'(pkt_rdy), int'(m_pkt));
        chk("R12 wdata_rdy", int'(wdata_rdy), int'(m_wdn));
        chk("R5 sect_req", int'(sect_req), int'(m_sr));
        chk("R10 unit_attn", int'(unit_attn), int'(m_ua));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic wreg(input logic [2:0] sel, input logic [15:0] v);
        b_wr = 1; b_sel = sel; b_wd = v;
        cyc();
        b_wr = 0;
    endtask

    task automatic rdchk(input logic [2:0] sel, input string tag, output int act);
        int exp;
        case (sel)
            3'd0: exp = (m_st == 2) ? int'({mem[m_off + 1], mem[m_off]}) : 0;
            3'd1: exp = int'(m_err);
            3'd2: exp = int'(m_irsn);
            3'd3: exp = 8'h81;
            3'd4: exp = int'(m_lo);
            3'd5: exp = int'(m_hi);
            default: exp = int'(m_status);
        endcase
        b_rd = 1; b_sel = sel;
        #1 act = int'(host_rdata);
        cyc();
        b_rd = 0;
        chk(tag, act, exp);
    endtask

    task automatic send_packet();
        wreg(3'd6, 16'h00A0);
        for (int k = 0; k < 6; k++) wreg(3'd0, 16'h1100 + 16'(k * 16'h0203));
    endtask

    int v;

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        cmp_all();
        // R1 reset state
        rdchk(3'd7, "R1 status", v); chk("R1 status literal", v, 8'h00);
        rdchk(3'd3, "R1 lba_lo", v);
        rdchk(3'd1, "R1 error", v);
        rdchk(3'd4, "R1 count", v);
        // R11 data read while idle
        rdchk(3'd0, "R11 idle data", v); chk("R11 idle data literal", v, 0);
        // R2 packet command
        wreg(3'd1, 16'h0002);
        wreg(3'd6, 16'h00A0);
        rdchk(3'd7, "R2 status", v); chk("R2 status literal", v, 8'h58);
        rdchk(3'd2, "R2 irsn", v);
        rdchk(3'd1, "R2 error", v); chk("R2 error literal", v, 2);
        rdchk(3'd0, "R11 rx data read", v);
        // R3 packet words
        for (int k = 0; k < 6; k++) wreg(3'd0, 16'hA000 + 16'(k * 16'h0111));
        rdchk(3'd7, "R3 status", v); chk("R3 status literal", v, 8'hD0);
        for (int k = 0; k < 6; k++)
            chk("R3 buffer word", int'({mem[2*k+1], mem[2*k]}), 16'hA000 + k * 16'h0111);
        // R11 write while busy ignored
        wreg(3'd0, 16'hBEEF);
        chk("R11 busy write", int'({mem[1], mem[0]}), 16'hA000);
        // R4 PIO read of two sectors of 6 bytes
        b_go = 1; b_gord = 1; b_glen = 6; b_gsec = 1; cyc(); b_go = 0;
        chk("R10 unit_attn cleared", int'(unit_attn), 0);
        rdchk(3'd7, "R4 status", v); chk("R4 status literal", v, 8'h58);
        rdchk(3'd2, "R4 irsn", v);
        rdchk(3'd4, "R4 count lo", v); chk("R4 count literal", v, 6);
        rdchk(3'd5, "R4 count hi", v);
        rdchk(3'd1, "R4 error", v);
        // R8 status read clears with BSY clear
        rdchk(3'd6, "R8 status read", v);
        chk("R8 irq cleared", int'(irq), 0);
        for (int k = 0; k < 3; k++) rdchk(3'd0, "R5 sector1 data", v);
        chk("R5 rearm irq", int'(irq), 1);
        for (int k = 0; k < 6; k++) mem[k] = 8'(8'hC0 + k);
        rdchk(3'd7, "R5 rearm status", v);
        for (int k = 0; k < 3; k++) rdchk(3'd0, "R5 sector2 data", v);
        rdchk(3'd7, "R5 end status", v); chk("R5 end literal", v, 8'h50);
        rdchk(3'd2, "R5 end irsn", v);
        rdchk(3'd0, "R11 after end data", v);
        // R7 mask
        wreg(3'd7, 16'h0002); chk("R7 masked", int'(irq), 0);
        wreg(3'd7, 16'h0000); chk("R7 unmasked", int'(irq), 1);
        // R8 alternate status never clears
        rdchk(3'd7, "R8 alt read", v); chk("R8 alt keeps irq", int'(irq), 1);
        // R9 commands
        wreg(3'd6, 16'h0055); chk("R9 unknown clears", int'(irq), 0);
        rdchk(3'd7, "R9 unknown status", v);
        wreg(3'd6, 16'h0000); rdchk(3'd7, "R9 nop", v); chk("R9 nop literal", v, 8'h51);
        wreg(3'd6, 16'h00EF); rdchk(3'd7, "R9 setf", v); chk("R9 setf literal", v, 8'h50);
        // R12 PIO write of 4 bytes
        send_packet();
        b_go = 1; b_gord = 0; b_glen = 4; b_gsec = 3; cyc(); b_go = 0;
        rdchk(3'd2, "R12 irsn start", v);
        wreg(3'd0, 16'h5A5A); wreg(3'd0, 16'h3C3C);
        rdchk(3'd7, "R12 status", v); chk("R12 status literal", v, 8'h50);
        rdchk(3'd2, "R12 irsn", v);
        chk("R12 buffer", int'({mem[3], mem[2]}), 16'h3C3C);
        // R6 DMA read of two sectors
        wreg(3'd1, 16'h0001);
        send_packet();
        b_go = 1; b_gord = 1; b_glen = 8; b_gsec = 1; cyc(); b_go = 0;
        rdchk(3'd7, "R6 status", v); chk("R6 status literal", v, 8'hD0);
        rdchk(3'd4, "R6 count kept", v); chk("R6 count literal", v, 4);
        chk("R6 no irq", int'(irq), 0);
        b_dma = 1; cyc(); b_dma = 0;
        rdchk(3'd6, "R8 busy status read", v); chk("R8 busy keeps irq", int'(irq), 1);
        b_dma = 1; cyc(); b_dma = 0;
        rdchk(3'd7, "R6 end status", v);
        // R10 completion with code
        wreg(3'd6, 16'h00A0);
        for (int k = 0; k < 6; k++) wreg(3'd0, 16'h0F00);
        b_end = 1; b_code = 4'h5; cyc(); b_end = 0;
        rdchk(3'd7, "R10 status", v); chk("R10 status literal", v, 8'h51);
        rdchk(3'd1, "R10 error", v); chk("R10 error literal", v, 8'h50);
        rdchk(3'd2, "R10 irsn", v);
        repeat (2) cyc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule